// File: doc/BRIEF.md
# Write Buffer with Read Bypass

This block sits between a cache and a slower next-level memory. Outgoing writes enter a small queue, whether they are write-through stores or dirty lines pushed out by a write-back cache. The queue sends them to memory in arrival order, one line per accepted memory request. When the cache reports a read miss, the block compares the miss address with every queued line. If no line matches, the read goes to memory ahead of the writes still waiting. If a line does match, the block answers the read from its own storage using the newest copy, and memory sees no read.

A typical eviction works like this: the cache pushes the displaced dirty line into the buffer and raises the read miss for the new line in the same cycle. The read reaches memory first. The requester is released when the read data comes back, and the displaced line is written afterwards. The block never empties the whole queue before a read.

Top module: `wbuf_bypass`

## Requirements
- R1: After reset the buffer is empty: `wr_ready` and `rd_ready` are 1, and `mem_req_valid` and `rd_resp_valid` are 0.
- R2: The buffer holds DEPTH lines (4 by default). `wr_ready` is 0 while DEPTH lines are held. An enqueue offered while `wr_ready` is 0 is not taken and never reaches memory.
- R3: Queued lines drain in arrival order. Each line is sent as one memory request with `mem_req_write`=1 that carries its own address and data.
- R4: A read miss that matches no queued line is the next memory request, with `mem_req_write`=0 and the miss address. A write that was already offered to memory but not yet accepted finishes first. The other queued writes stay behind the read until the read request is accepted.
- R5: For a read sent to memory, `rd_resp_valid` rises in the same cycle as `mem_resp_valid`, with `rd_resp_data` equal to `mem_resp_data`. This does not wait for queued writes, including a victim line that is still pending.
- R6: A read miss that matches one or more queued lines is answered one cycle after acceptance with the data of the newest matching line. No memory read is issued for it.
- R7: A read accepted in the same cycle as an enqueue to the same address returns the data being enqueued.
- R8: When a victim line (a different address) is enqueued in the same cycle as a read miss, the read reaches memory before the victim's write.
- R9: Only one read is outstanding at a time. `rd_ready` is 0 from the cycle after a read is accepted until its response has been given.
- R10: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the memory request (valid, write flag, address, data) holds steady into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Cache offers a line to enqueue |
| wr_ready | output | 1 | Buffer can accept a line |
| wr_addr | input | AW | Line address of the enqueued write |
| wr_data | input | DW | Line data of the enqueued write |
| rd_valid | input | 1 | Cache raises a read miss |
| rd_ready | output | 1 | Block accepts a read miss |
| rd_addr | input | AW | Read-miss line address |
| rd_resp_valid | output | 1 | Read data returned to the cache |
| rd_resp_data | output | DW | Read data (forwarded or from memory) |
| mem_req_valid | output | 1 | Request offered to memory |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = line write, 0 = read |
| mem_req_addr | output | AW | Request address |
| mem_req_wdata | output | DW | Write data (0 for reads) |
| mem_resp_valid | input | 1 | Memory returns read data |
| mem_resp_data | input | DW | Memory read data |

## Verification
The bench builds the block with DEPTH=4, AW=8 and DW=16. The narrow address lets a 256-word memory model track every line exactly. Four enqueues are enough to reach the full-buffer stall. The bench holds memory ready low at chosen moments, which freezes a queued write in front of memory. This brings within reach the committed-write-first ordering, forwarding from a line that cannot drain, and a response that arrives while the victim write is still blocked.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

  typedef enum logic [1:0] {
    RS_IDLE,
    RS_FWD,
    RS_ISSUE,
    RS_WAIT
  } rd_state_e;

  // Position `off` slots after `base` in a ring of `depth` slots.
  function automatic int unsigned ring_add(int unsigned base, int unsigned off,
                                           int unsigned depth);
    int unsigned s;
    s = base + off;
    while (s >= depth) s = s - depth;
    return s;
  endfunction

endpackage

// File: rtl/wbuf_store.sv
module wbuf_store
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 64,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  logic [AW-1:0]             push_addr,
  input  logic [DW-1:0]             push_data,
  input  logic                      pop,
  output logic                      full,
  output logic                      empty,
  output logic [PW-1:0]             head_ptr,
  output logic [AW-1:0]             head_addr,
  output logic [DW-1:0]             head_data,
  output logic [DEPTH-1:0][AW-1:0]  slot_addr,
  output logic [DEPTH-1:0][DW-1:0]  slot_data,
  output logic [DEPTH-1:0]          slot_valid
);

  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][AW-1:0] addr_q;
  logic [DEPTH-1:0][DW-1:0] data_q;
  logic [DEPTH-1:0]         vld_q;
  logic [PW-1:0]            head_q, tail_q;
  logic [CW-1:0]            occ_q;

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[tail_q] <= push_addr;
      data_q[tail_q] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else begin
      if (push) begin
        vld_q[tail_q] <= 1'b1;
        tail_q        <= PW'(ring_add(int'(tail_q), 1, DEPTH));
      end
      if (pop) begin
        vld_q[head_q] <= 1'b0;
        head_q        <= PW'(ring_add(int'(head_q), 1, DEPTH));
      end
      case ({push, pop})
        2'b10:   occ_q <= occ_q + 1'b1;
        2'b01:   occ_q <= occ_q - 1'b1;
        default: occ_q <= occ_q;
      endcase
    end
  end

  assign full       = (occ_q == CW'(DEPTH));
  assign empty      = (occ_q == '0);
  assign head_ptr   = head_q;
  assign head_addr  = addr_q[head_q];
  assign head_data  = data_q[head_q];
  assign slot_addr  = addr_q;
  assign slot_data  = data_q;
  assign slot_valid = vld_q;

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  a_r2_valid_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld_q) == int'(occ_q));

  a_r3_head_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !empty |-> vld_q[head_q]);

endmodule

// File: rtl/wbuf_lookup.sv
module wbuf_lookup
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 64,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][AW-1:0] slot_addr,
  input  logic [DEPTH-1:0][DW-1:0] slot_data,
  input  logic [DEPTH-1:0]         slot_valid,
  input  logic [PW-1:0]            head_ptr,
  input  logic [AW-1:0]            look_addr,
  input  logic                     new_valid,
  input  logic [AW-1:0]            new_addr,
  input  logic [DW-1:0]            new_data,
  output logic                     hit,
  output logic [DW-1:0]            hit_data
);

  logic [DEPTH-1:0] slot_match;

  // One comparator per slot.
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign slot_match[g] = slot_valid[g] && (slot_addr[g] == look_addr);
  end

  // Walk oldest to newest so the last match seen is the newest one;
  // a same-cycle enqueue is newer than every stored slot.
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (slot_match[ring_add(int'(head_ptr), k, DEPTH)]) begin
        hit      = 1'b1;
        hit_data = slot_data[ring_add(int'(head_ptr), k, DEPTH)];
      end
    end
    if (new_valid && (new_addr == look_addr)) begin
      hit      = 1'b1;
      hit_data = new_data;
    end
  end

endmodule

// File: rtl/wbuf_bypass.sv
module wbuf_bypass
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_resp_valid,
  output logic [DW-1:0] rd_resp_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_resp_valid,
  input  logic [DW-1:0] mem_resp_data
);

  localparam int PW = $clog2(DEPTH);

  // Named internal events
  logic push, pop, rd_take, rd_hit, issue_rd, drain_go;
  logic full, empty;
  logic [PW-1:0]            head_ptr;
  logic [AW-1:0]            head_addr;
  logic [DW-1:0]            head_data, hit_data;
  logic [DEPTH-1:0][AW-1:0] slot_addr;
  logic [DEPTH-1:0][DW-1:0] slot_data;
  logic [DEPTH-1:0]         slot_valid;

  rd_state_e     state;
  logic          wr_hold;
  logic [AW-1:0] rd_addr_q;
  logic [DW-1:0] fwd_q;

  wbuf_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push),
    .push_addr  (wr_addr),
    .push_data  (wr_data),
    .pop        (pop),
    .full       (full),
    .empty      (empty),
    .head_ptr   (head_ptr),
    .head_addr  (head_addr),
    .head_data  (head_data),
    .slot_addr  (slot_addr),
    .slot_data  (slot_data),
    .slot_valid (slot_valid)
  );

  wbuf_lookup #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_lookup (
    .slot_addr  (slot_addr),
    .slot_data  (slot_data),
    .slot_valid (slot_valid),
    .head_ptr   (head_ptr),
    .look_addr  (rd_addr),
    .new_valid  (push),
    .new_addr   (wr_addr),
    .new_data   (wr_data),
    .hit        (rd_hit),
    .hit_data   (hit_data)
  );

  // Cache side
  assign wr_ready = !full;
  assign push     = wr_valid && wr_ready;
  assign rd_ready = (state == RS_IDLE);
  assign rd_take  = rd_valid && rd_ready;

  // Memory side: a read waiting to issue pre-empts the drain, except for
  // a write already offered and not yet accepted (it must stay put).
  assign issue_rd = (state == RS_ISSUE) && !wr_hold;
  assign drain_go = !empty && !issue_rd;
  assign pop      = drain_go && mem_req_ready;

  assign mem_req_valid = issue_rd || drain_go;
  assign mem_req_write = !issue_rd;
  assign mem_req_addr  = issue_rd ? rd_addr_q : head_addr;
  assign mem_req_wdata = issue_rd ? '0 : head_data;

  assign rd_resp_valid = (state == RS_FWD) || ((state == RS_WAIT) && mem_resp_valid);
  assign rd_resp_data  = (state == RS_FWD) ? fwd_q : mem_resp_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= RS_IDLE;
      wr_hold <= 1'b0;
    end else begin
      wr_hold <= drain_go && !mem_req_ready;
      case (state)
        RS_IDLE:  if (rd_take) state <= rd_hit ? RS_FWD : RS_ISSUE;
        RS_FWD:   state <= RS_IDLE;
        RS_ISSUE: if (issue_rd && mem_req_ready) state <= RS_WAIT;
        RS_WAIT:  if (mem_resp_valid) state <= RS_IDLE;
        default:  state <= RS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rd_take) begin
      rd_addr_q <= rd_addr;
      fwd_q     <= hit_data;
    end
  end

  a_r4_read_first: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && !rd_hit && !(mem_req_valid && mem_req_write && !mem_req_ready))
    |=> (mem_req_valid && !mem_req_write && mem_req_addr == $past(rd_addr)));

  a_r6_fwd_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && rd_hit) |=> (rd_resp_valid && !(mem_req_valid && !mem_req_write)));

  a_r7_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && push && wr_addr == rd_addr)
    |=> (rd_resp_valid && rd_resp_data == $past(wr_data)));

  a_r9_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_resp_valid |-> !rd_ready);

  a_r10_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready)
    |=> (mem_req_valid && $stable(mem_req_write) && $stable(mem_req_addr)
         && $stable(mem_req_wdata)));

endmodule

// File: tb/wbuf_bypass_test.sv
module wbuf_bypass_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int AW    = 8;
  localparam int DW    = 16;
  localparam int LAT   = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_valid = 1'b0;
  logic          rd_ready;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_resp_valid;
  logic [DW-1:0] rd_resp_data;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b1;
  logic          mem_req_write;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_resp_valid = 1'b0;
  logic [DW-1:0] mem_resp_data = '0;

  int n_chk = 0;
  int n_bad = 0;

  wbuf_bypass #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] init_val(logic [AW-1:0] a);
    return {a, ~a};
  endfunction

  // Memory model and request log: one process, samples at posedge,
  // drives the response at negedge.
  logic [DW-1:0] mem_model [256];
  logic          log_wr   [64];
  logic [AW-1:0] log_addr [64];
  logic [DW-1:0] log_data [64];
  int            log_n  = 0;
  int            resp_n = 0;
  logic [DW-1:0] resp_last = '0;

  initial begin
    int            pend;
    logic [DW-1:0] pend_data;
    pend = 0;
    pend_data = '0;
    for (int i = 0; i < 256; i++) mem_model[i] = init_val(AW'(i));
    forever begin
      @(posedge clk);
      if (rst_n && rd_resp_valid) begin
        resp_n++;
        resp_last = rd_resp_data;
      end
      if (rst_n && mem_req_valid && mem_req_ready) begin
        if (log_n < 64) begin
          log_wr[log_n]   = mem_req_write;
          log_addr[log_n] = mem_req_addr;
          log_data[log_n] = mem_req_wdata;
        end
        log_n++;
        if (mem_req_write) mem_model[mem_req_addr] = mem_req_wdata;
        else begin
          pend      = LAT;
          pend_data = mem_model[mem_req_addr];
        end
      end
      @(negedge clk);
      mem_resp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_resp_valid = 1'b1;
          mem_resp_data  = pend_data;
        end
      end
    end
  end

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic enq(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(posedge clk);
    #1 wr_valid = 1'b0;
  endtask

  task automatic rd_req(input logic [AW-1:0] a);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a;
    while (!rd_ready) @(negedge clk);
    @(posedge clk);
    #1 rd_valid = 1'b0;
  endtask

  task automatic wait_log(input int n);
    for (int i = 0; i < 200 && log_n < n; i++) @(negedge clk);
  endtask

  task automatic wait_resp(input int n);
    for (int i = 0; i < 200 && resp_n < n; i++) @(negedge clk);
  endtask

  task automatic check_log(input int idx, input bit w, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input string what);
    check(log_wr[idx] == w, what, log_wr[idx], w);
    check(log_addr[idx] == a, what, log_addr[idx], a);
    if (w) check(log_data[idx] == d, what, log_data[idx], d);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(wr_ready == 1'b1, "R1 wr_ready after reset", wr_ready, 1);
    check(rd_ready == 1'b1, "R1 rd_ready after reset", rd_ready, 1);
    check(mem_req_valid == 1'b0, "R1 no mem request", mem_req_valid, 0);
    check(rd_resp_valid == 1'b0, "R1 no read response", rd_resp_valid, 0);
  endtask

  task automatic t_fill_drain;
    int base;
    base = log_n;
    mem_req_ready = 1'b0;
    for (int i = 0; i < DEPTH; i++) enq(AW'(10 + i), DW'(16'h1000 + i));
    @(negedge clk);
    check(wr_ready == 1'b0, "R2 full stalls enqueue", wr_ready, 0);
    wr_valid = 1'b1; wr_addr = 8'd14; wr_data = 16'hDEAD;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(mem_req_valid && mem_req_write && mem_req_addr == 8'd10,
            "R10 held write request", mem_req_addr, 10);
    end
    wr_valid = 1'b0;
    mem_req_ready = 1'b1;
    wait_log(base + DEPTH);
    repeat (4) @(negedge clk);
    check(log_n == base + DEPTH, "R2 refused enqueue not written", log_n, base + DEPTH);
    for (int i = 0; i < DEPTH; i++)
      check_log(base + i, 1'b1, AW'(10 + i), DW'(16'h1000 + i), "R3 drain order");
  endtask

  task automatic t_bypass;
    int base, r0;
    base = log_n; r0 = resp_n;
    mem_req_ready = 1'b0;
    enq(8'd20, 16'h2020); enq(8'd21, 16'h2121); enq(8'd22, 16'h2222);
    rd_req(8'd30);
    @(negedge clk);
    check(rd_ready == 1'b0, "R9 rd_ready low while read outstanding", rd_ready, 0);
    mem_req_ready = 1'b1;
    wait_log(base + 4);
    check_log(base,     1'b1, 8'd20, 16'h2020, "R4 offered write first");
    check_log(base + 1, 1'b0, 8'd30, '0,       "R4 read overtakes queue");
    check_log(base + 2, 1'b1, 8'd21, 16'h2121, "R4 queued write after read");
    check_log(base + 3, 1'b1, 8'd22, 16'h2222, "R4 queued write after read");
    wait_resp(r0 + 1);
    check(resp_last == init_val(8'd30), "R5 read data from memory", resp_last, init_val(8'd30));
    @(negedge clk);
    check(rd_ready == 1'b1, "R9 rd_ready back after response", rd_ready, 1);
  endtask

  task automatic t_evict;
    int base, r0;
    repeat (4) @(negedge clk);
    base = log_n; r0 = resp_n;
    mem_req_ready = 1'b1;
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 8'd40; wr_data = 16'h4040;
    rd_valid = 1'b1; rd_addr = 8'd50;
    @(posedge clk);
    #1 wr_valid = 1'b0; rd_valid = 1'b0;
    for (int i = 0; i < 50 && log_n <= base; i++) @(negedge clk);
    mem_req_ready = 1'b0;
    check_log(base, 1'b0, 8'd50, '0, "R8 read before victim write");
    wait_resp(r0 + 1);
    check(resp_last == init_val(8'd50), "R5 evict read data", resp_last, init_val(8'd50));
    check(mem_req_valid && mem_req_write && mem_req_addr == 8'd40,
          "R5 response while victim pending", mem_req_addr, 40);
    mem_req_ready = 1'b1;
    wait_log(base + 2);
    check_log(base + 1, 1'b1, 8'd40, 16'h4040, "R8 victim written after read");
  endtask

  task automatic t_forward;
    int base;
    repeat (4) @(negedge clk);
    base = log_n;
    mem_req_ready = 1'b0;
    enq(8'd60, 16'hA000); enq(8'd61, 16'hB000); enq(8'd60, 16'hC000);
    rd_req(8'd60);
    @(negedge clk);
    check(rd_resp_valid == 1'b1, "R6 forward response next cycle", rd_resp_valid, 1);
    check(rd_resp_data == 16'hC000, "R6 newest matching data", rd_resp_data, 16'hC000);
    check(mem_req_write == 1'b1, "R6 no memory read", mem_req_write, 1);
    mem_req_ready = 1'b1;
    wait_log(base + 3);
    repeat (6) @(negedge clk);
    check(log_n == base + 3, "R6 only the three writes reach memory", log_n, base + 3);
    check_log(base + 2, 1'b1, 8'd60, 16'hC000, "R3 drain after forward");
  endtask

  task automatic t_same_cycle;
    int base;
    repeat (4) @(negedge clk);
    base = log_n;
    mem_req_ready = 1'b0;
    enq(8'd70, 16'h7001);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 8'd70; wr_data = 16'h7002;
    rd_valid = 1'b1; rd_addr = 8'd70;
    @(posedge clk);
    #1 wr_valid = 1'b0; rd_valid = 1'b0;
    @(negedge clk);
    check(rd_resp_valid && rd_resp_data == 16'h7002, "R7 same-cycle enqueue forwarded",
          rd_resp_data, 16'h7002);
    check(rd_ready == 1'b0, "R9 rd_ready low during response", rd_ready, 0);
    mem_req_ready = 1'b1;
    wait_log(base + 2);
    check_log(base,     1'b1, 8'd70, 16'h7001, "R3 older copy first");
    check_log(base + 1, 1'b1, 8'd70, 16'h7002, "R3 newer copy second");
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_fill_drain();
    t_bypass();
    t_evict();
    t_forward();
    t_same_cycle();
    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule